// File: doc/BRIEF.md
# Master Sync Timestamp Sequencer

This block is the master end of a three-message time-alignment exchange. It keeps a free-running time count and, once every programmed interval, asks the frame codec to send a request frame. The egress time of that request is captured in hardware in the cycle the codec signals that the frame has started on the line. That captured value is what the codec inserts into the same frame, so no follow-up frame is needed. When the slave's reply comes back, the time count captured at the reply's start-of-frame strobe is kept. The block then asks the codec to send a report frame that carries this value.

The codec exchanges field-level requests with the block. The block presents `tx_req` together with a kind code and a timestamp payload. The codec pulses `tx_sof` when the frame starts on the line and `tx_done` when the frame ends. On the receive side, `rx_sof` marks the start of an incoming frame, and `rx_valid` with `rx_kind` reports a fully checked frame. The interval comes from a software register value on `period_cfg`. A new value is picked up only at a period boundary. If a boundary arrives while an exchange is still unfinished, that exchange is dropped and a fresh request is launched.

Top module: `msq_master_sync`

## Requirements
- R1: While reset is held, `time_now` is 0 and `tx_req` is low; after release, `time_now` rises by exactly 1 every clock cycle (modulo 2^TW).
- R2: A period boundary occurs first in the cycle where `time_now` equals DEF_PERIOD. From that cycle, `tx_req` is high with `tx_kind` = 8'hA1 (request), unless a frame is on the line.
- R3: Each later boundary follows the previous one by the interval length in force. That length is the value of `period_cfg` seen in the cycle just before the previous boundary, so a write made mid-interval affects only the interval after the next boundary.
- R4: A `period_cfg` value below MIN_PERIOD (0 included) is treated as MIN_PERIOD cycles.
- R5: From the cycle after a `tx_sof` pulse for a request, `tx_stamp` equals the `time_now` value of the `tx_sof` cycle.
- R6: While awaiting a reply, `rx_valid` with `rx_kind` = 8'h51 makes `tx_req` high in the next cycle. In that cycle `tx_kind` = 8'hA2 (report) and `tx_stamp` equals the `time_now` value seen at the most recent `rx_sof` pulse.
- R7: A frame with kind 8'h51 that arrives with no request outstanding is ignored, and so is any other kind code while waiting. Neither raises `tx_req` or changes `tx_stamp`.
- R8: A boundary that arrives while a request or report has not yet started, or while a reply is still awaited, abandons that exchange. `tx_req` is then high with kind 8'hA1 in the boundary cycle.
- R9: A boundary that arrives while a frame is on the line leaves `tx_req` low until that frame's `tx_done`. In the cycle after `tx_done`, `tx_req` is high with kind 8'hA1.
- R10: `tx_req` drops in the cycle after `tx_sof`. After the report's `tx_done`, it stays low until the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_cfg | input | PW | Request interval in cycles, from a software register |
| tx_req | output | 1 | Frame send request to the codec |
| tx_kind | output | 8 | Kind code of the requested frame (8'hA1 request, 8'hA2 report) |
| tx_stamp | output | TW | Timestamp payload for the frame |
| tx_sof | input | 1 | Codec pulse: outgoing frame starts on the line |
| tx_done | input | 1 | Codec pulse: outgoing frame finished |
| rx_sof | input | 1 | Codec pulse: incoming frame starts on the line |
| rx_valid | input | 1 | Codec pulse: incoming frame fully received and checked |
| rx_kind | input | 8 | Kind code of the received frame, valid with rx_valid |
| time_now | output | TW | Free-running master time count |

## Verification
The assertions assume that the codec pulses `tx_sof` only while `tx_req` is high, and pulses `tx_done` once per started frame. They also assume that each `rx_valid` follows its own `rx_sof`. The stimulus models the codec and the slave as tasks that produce exactly one such sequence per frame, with random gaps and frame lengths. Ordinary exchanges start at a boundary and are kept shorter than the programmed interval. Boundaries land mid-exchange only in directed cases: a silent codec, a missing reply, a stalled report and an overlong request frame.

// File: rtl/msq_pkg.sv
package msq_pkg;

    localparam logic [7:0] KIND_REQUEST = 8'hA1;
    localparam logic [7:0] KIND_REPLY   = 8'h51;
    localparam logic [7:0] KIND_REPORT  = 8'hA2;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_LAUNCH_REQ,
        XS_SEND_REQ,
        XS_AWAIT_REPLY,
        XS_LAUNCH_RPT,
        XS_SEND_RPT
    } xstate_e;

endpackage

// File: rtl/msq_timebase.sv
module msq_timebase #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] time_now
);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tb_t;

    tb_t tb_d, tb_q;

    always_comb begin
        tb_d     = tb_q;
        tb_d.cnt = tb_q.cnt + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign time_now = tb_q.cnt;

endmodule

// File: rtl/msq_pacer.sv
module msq_pacer #(
    parameter int PW         = 24,
    parameter int DEF_PERIOD = 1000,
    parameter int MIN_PERIOD = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period_cfg,
    output logic          tick
);

    localparam logic [PW-1:0] MIN_P = PW'(MIN_PERIOD);
    localparam logic [PW-1:0] DEF_P = (DEF_PERIOD < MIN_PERIOD) ? PW'(MIN_PERIOD)
                                                                : PW'(DEF_PERIOD);

    typedef struct packed {
        logic [PW-1:0] ctr;
        logic [PW-1:0] len;
    } pace_t;

    pace_t pc_d, pc_q;
    logic  last_cycle;

    always_comb begin
        pc_d       = pc_q;
        last_cycle = (pc_q.ctr == pc_q.len - PW'(1));
        if (last_cycle) begin
            pc_d.ctr = '0;
            pc_d.len = (period_cfg < MIN_P) ? MIN_P : period_cfg;
        end else begin
            pc_d.ctr = pc_q.ctr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q.ctr <= '0;
            pc_q.len <= DEF_P;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign tick = last_cycle;

endmodule

// File: rtl/msq_ingress.sv
module msq_ingress
    import msq_pkg::*;
#(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] time_now,
    input  logic          rx_sof,
    input  logic          rx_valid,
    input  logic [7:0]    rx_kind,
    output logic          reply_hit,
    output logic [TW-1:0] reply_time
);

    typedef struct packed {
        logic [TW-1:0] cap;
    } ing_t;

    ing_t ig_d, ig_q;

    always_comb begin
        ig_d = ig_q;
        if (rx_sof) ig_d.cap = time_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ig_q <= '0;
        else        ig_q <= ig_d;
    end

    assign reply_hit  = rx_valid && (rx_kind == KIND_REPLY);
    assign reply_time = ig_q.cap;

endmodule

// File: rtl/msq_exchange.sv
module msq_exchange
    import msq_pkg::*;
#(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [TW-1:0] time_now,
    input  logic          tx_sof,
    input  logic          tx_done,
    input  logic          reply_hit,
    input  logic [TW-1:0] reply_time,
    output logic          tx_req,
    output logic [7:0]    tx_kind,
    output logic [TW-1:0] tx_stamp
);

    typedef struct packed {
        xstate_e       st;
        logic          relaunch;
        logic [TW-1:0] stamp;
    } xreg_t;

    xreg_t xr_d, xr_q;

    always_comb begin
        xr_d = xr_q;
        unique case (xr_q.st)
            XS_IDLE: begin
                if (tick) xr_d.st = XS_LAUNCH_REQ;
            end
            XS_LAUNCH_REQ: begin
                if (tx_sof) begin
                    xr_d.st    = XS_SEND_REQ;
                    xr_d.stamp = time_now;
                end
            end
            XS_SEND_REQ: begin
                if (tx_done) begin
                    xr_d.st       = (xr_q.relaunch || tick) ? XS_LAUNCH_REQ : XS_AWAIT_REPLY;
                    xr_d.relaunch = 1'b0;
                end else if (tick) begin
                    xr_d.relaunch = 1'b1;
                end
            end
            XS_AWAIT_REPLY: begin
                if (tick) begin
                    xr_d.st = XS_LAUNCH_REQ;
                end else if (reply_hit) begin
                    xr_d.st    = XS_LAUNCH_RPT;
                    xr_d.stamp = reply_time;
                end
            end
            XS_LAUNCH_RPT: begin
                if (tx_sof)    xr_d.st = XS_SEND_RPT;
                else if (tick) xr_d.st = XS_LAUNCH_REQ;
            end
            XS_SEND_RPT: begin
                if (tx_done) begin
                    xr_d.st       = (xr_q.relaunch || tick) ? XS_LAUNCH_REQ : XS_IDLE;
                    xr_d.relaunch = 1'b0;
                end else if (tick) begin
                    xr_d.relaunch = 1'b1;
                end
            end
            default: xr_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xr_q.st       <= XS_IDLE;
            xr_q.relaunch <= 1'b0;
            xr_q.stamp    <= '0;
        end else begin
            xr_q <= xr_d;
        end
    end

    assign tx_req   = (xr_q.st == XS_LAUNCH_REQ) || (xr_q.st == XS_LAUNCH_RPT);
    assign tx_kind  = ((xr_q.st == XS_LAUNCH_RPT) || (xr_q.st == XS_SEND_RPT)) ? KIND_REPORT
                                                                             : KIND_REQUEST;
    assign tx_stamp = xr_q.stamp;

endmodule

// File: rtl/msq_master_sync.sv
module msq_master_sync #(
    parameter int TW         = 32,
    parameter int PW         = 24,
    parameter int DEF_PERIOD = 1000,
    parameter int MIN_PERIOD = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period_cfg,
    output logic          tx_req,
    output logic [7:0]    tx_kind,
    output logic [TW-1:0] tx_stamp,
    input  logic          tx_sof,
    input  logic          tx_done,
    input  logic          rx_sof,
    input  logic          rx_valid,
    input  logic [7:0]    rx_kind,
    output logic [TW-1:0] time_now
);

    logic          tick;
    logic          reply_hit;
    logic [TW-1:0] reply_time;

    msq_timebase #(.TW(TW)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .time_now (time_now)
    );

    msq_pacer #(
        .PW         (PW),
        .DEF_PERIOD (DEF_PERIOD),
        .MIN_PERIOD (MIN_PERIOD)
    ) u_pace (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_cfg (period_cfg),
        .tick       (tick)
    );

    msq_ingress #(.TW(TW)) u_ingress (
        .clk        (clk),
        .rst_n      (rst_n),
        .time_now   (time_now),
        .rx_sof     (rx_sof),
        .rx_valid   (rx_valid),
        .rx_kind    (rx_kind),
        .reply_hit  (reply_hit),
        .reply_time (reply_time)
    );

    msq_exchange #(.TW(TW)) u_exch (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .time_now   (time_now),
        .tx_sof     (tx_sof),
        .tx_done    (tx_done),
        .reply_hit  (reply_hit),
        .reply_time (reply_time),
        .tx_req     (tx_req),
        .tx_kind    (tx_kind),
        .tx_stamp   (tx_stamp)
    );

endmodule

// File: rtl/msq_master_sync_chk.sv
module msq_master_sync_chk #(
    parameter int TW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_req,
    input logic [7:0]    tx_kind,
    input logic [TW-1:0] tx_stamp,
    input logic          tx_sof,
    input logic          rx_valid,
    input logic [7:0]    rx_kind,
    input logic [TW-1:0] time_now
);

    // R1
    time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> time_now == $past(time_now) + TW'(1));

    // R2
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> (tx_kind == 8'hA1 || tx_kind == 8'hA2));

    // R5
    egress_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_sof && tx_kind == 8'hA1) |=> tx_stamp == $past(time_now));

    // R6
    report_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_kind == 8'hA2 && !$past(tx_req)) |-> $past(rx_valid && rx_kind == 8'h51));

    // R10
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_sof) |=> !tx_req);

endmodule

bind msq_master_sync msq_master_sync_chk #(.TW(TW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_req   (tx_req),
    .tx_kind  (tx_kind),
    .tx_stamp (tx_stamp),
    .tx_sof   (tx_sof),
    .rx_valid (rx_valid),
    .rx_kind  (rx_kind),
    .time_now (time_now)
);

// File: tb/msq_master_sync_test.sv
module msq_master_sync_test;

    localparam int TW   = 32;
    localparam int PW   = 24;
    localparam int DEFP = 100;
    localparam int MINP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] period_cfg = PW'(150);
    logic          tx_req;
    logic [7:0]    tx_kind;
    logic [TW-1:0] tx_stamp;
    logic          tx_sof = 1'b0;
    logic          tx_done = 1'b0;
    logic          rx_sof = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_kind = 8'h00;
    logic [TW-1:0] time_now;

    msq_master_sync #(.TW(TW), .PW(PW), .DEF_PERIOD(DEFP), .MIN_PERIOD(MINP)) uut (
        .clk(clk), .rst_n(rst_n), .period_cfg(period_cfg),
        .tx_req(tx_req), .tx_kind(tx_kind), .tx_stamp(tx_stamp),
        .tx_sof(tx_sof), .tx_done(tx_done),
        .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_kind(rx_kind),
        .time_now(time_now)
    );

    always #2 clk = ~clk;

    int            n_checks = 0;
    int            n_fail   = 0;
    logic [31:0]   ncyc     = 0;
    logic [31:0]   exp_rise = DEFP;
    logic [PW-1:0] cfg_seen;
    bit            a1_prev  = 1'b0;
    bit            hold_flag = 1'b0;
    bit            late_ok  = 1'b0;
    bit            finished = 1'b0;
    event          boundary_ev;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] eff_len(input logic [PW-1:0] cfg);
        return (cfg < PW'(MINP)) ? 32'(MINP) : 32'(cfg);
    endfunction

    always @(posedge clk) begin
        if (rst_n) ncyc <= ncyc + 1;
        cfg_seen <= period_cfg;
    end

    // boundary model: R1 count, R3/R4 interval lengths, R8 abandon, R9 hold
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit a1_now;
            a1_now = tx_req && (tx_kind == 8'hA1);
            chk(time_now == ncyc, "R1 time count", time_now, ncyc);
            if (ncyc == exp_rise) begin
                if (hold_flag) begin
                    chk(!tx_req, "R9 no request while frame on line", tx_req, 0);
                    hold_flag = 1'b0;
                end else begin
                    chk(a1_now, "R2 R3 R4 R8 request at boundary", {tx_req, tx_kind}, 9'h1A1);
                end
                exp_rise = exp_rise + eff_len(cfg_seen);
                ->boundary_ev;
            end else if (a1_now && !a1_prev && !late_ok) begin
                chk(1'b0, "R3 request off boundary", ncyc, exp_rise);
            end
            a1_prev = a1_now;
        end
    end

    always @(posedge clk) begin
        if (ncyc > 32'd150000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=done", ncyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic send_frame(input logic [7:0] kind, output logic [31:0] sof_t);
        chk(tx_req && tx_kind == kind, "R2 R6 request kind", {tx_req, tx_kind}, {1'b1, kind});
        repeat ($urandom_range(1, 3)) @(negedge clk);
        tx_sof = 1'b1;
        sof_t  = ncyc;
        @(negedge clk);
        tx_sof = 1'b0;
        chk(!tx_req, "R10 request drops after start", tx_req, 0);
        repeat ($urandom_range(4, 8)) @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic slave_frame(input logic [7:0] code, output logic [31:0] cap_t);
        repeat ($urandom_range(1, 4)) @(negedge clk);
        rx_sof = 1'b1;
        cap_t  = ncyc;
        @(negedge clk);
        rx_sof = 1'b0;
        repeat ($urandom_range(3, 9)) @(negedge clk);
        rx_valid = 1'b1;
        rx_kind  = code;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_kind  = 8'h00;
    endtask

    // request sent, reply received, report pending on return
    task automatic first_half(input bit junk, output logic [31:0] ic);
        logic [31:0] es, dummy;
        send_frame(8'hA1, es);
        chk(tx_stamp == es, "R5 egress stamp", tx_stamp, es);
        if ($urandom_range(0, 1) == 1) period_cfg = PW'($urandom_range(120, 250));
        if (junk) begin
            slave_frame(8'h52, dummy);
            chk(!tx_req && tx_stamp == es, "R7 other kind ignored", {tx_req, tx_stamp}, {1'b0, es});
        end
        slave_frame(8'h51, ic);
        chk(tx_req && tx_kind == 8'hA2 && tx_stamp == ic, "R6 report with ingress stamp",
            {tx_req, tx_kind, tx_stamp}, {1'b1, 8'hA2, ic});
    endtask

    task automatic full_exchange(input bit junk, input bit stray);
        logic [31:0] ic, es, dummy;
        first_half(junk, ic);
        send_frame(8'hA2, es);
        chk(!tx_req && tx_stamp == ic, "R10 idle after report", {tx_req, tx_stamp}, {1'b0, ic});
        if (stray) begin
            slave_frame(8'h51, dummy);
            repeat (2) begin
                chk(!tx_req && tx_stamp == ic, "R7 stray reply ignored", {tx_req, tx_stamp}, {1'b0, ic});
                @(negedge clk);
            end
        end
    endtask

    initial begin
        logic [31:0] es, ic;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(time_now == 0 && !tx_req, "R1 reset state", {tx_req, time_now}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // first boundary at DEF period, then plain exchanges
        @(boundary_ev);
        full_exchange(1'b0, 1'b1);

        for (int i = 0; i < 20; i++) begin
            @(boundary_ev);
            full_exchange($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
        end

        // R8: codec silent, request stays pending across a boundary
        period_cfg = PW'(130);
        @(boundary_ev);
        @(boundary_ev);
        chk(tx_req && tx_kind == 8'hA1, "R8 pending request relaunched", {tx_req, tx_kind}, 9'h1A1);
        full_exchange(1'b0, 1'b0);

        // R8: reply never arrives
        @(boundary_ev);
        send_frame(8'hA1, es);
        @(boundary_ev);
        chk(tx_req && tx_kind == 8'hA1, "R8 missing reply abandoned", {tx_req, tx_kind}, 9'h1A1);
        full_exchange(1'b0, 1'b0);

        // R8: report never started before boundary
        @(boundary_ev);
        first_half(1'b0, ic);
        @(boundary_ev);
        chk(tx_req && tx_kind == 8'hA1, "R8 stalled report abandoned", {tx_req, tx_kind}, 9'h1A1);
        full_exchange(1'b0, 1'b0);

        // R9: request frame still on the line at the boundary
        @(boundary_ev);
        late_ok = 1'b1;
        @(negedge clk);
        tx_sof = 1'b1;
        es     = ncyc;
        @(negedge clk);
        tx_sof    = 1'b0;
        hold_flag = 1'b1;
        @(boundary_ev);
        repeat (4) @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        chk(tx_req && tx_kind == 8'hA1, "R9 relaunch after frame end", {tx_req, tx_kind}, 9'h1A1);
        chk(tx_stamp == es, "R5 long frame stamp", tx_stamp, es);
        @(negedge clk);
        late_ok = 1'b0;
        full_exchange(1'b1, 1'b1);

        // R4: intervals below the minimum, codec silent
        @(boundary_ev);
        period_cfg = PW'(0);
        repeat (3) @(boundary_ev);
        period_cfg = PW'(5);
        repeat (3) @(boundary_ev);
        period_cfg = PW'(140);
        repeat (2) @(boundary_ev);
        full_exchange(1'b0, 1'b0);

        for (int i = 0; i < 6; i++) begin
            @(boundary_ev);
            full_exchange($urandom_range(0, 1) == 1, 1'b0);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule